// File: doc/BRIEF.md
# Segment LCD Frame Timer

This block turns a slow reference clock into the timing skeleton of a multiplexed segment LCD. Two counters in series set the period of one common phase. The first is a power-of-two prescaler and the second is a small integer divider. Both take their codes from a single frame-rate configuration word. Each elapsed phase produces a one-cycle tick and moves a common-phase index forward. When the index wraps after the last active common, the block flags the end of a frame. Each tick also starts a buffer drive-enable pulse whose length is programmable.

The block is clocked at twice the slow-clock rate. With the default `SUB_LOG2 = 1`, one slow-clock period is two `clk_i` cycles, so the half-period buffer setting can be expressed as a whole number of cycles. Every duration below is given in `clk_i` cycles at the default parameters. While `en_i` is low the block is idle. A rising `en_i`, or any change to either divide code, starts the phase timing over from zero.

Top module: `lcd_frame_timer`

## Requirements
- R1: The prescaler code n in `rate_cfg_i[2:0]` divides the slow clock by 8·2^n. One common phase therefore lasts 16·2^n·(m+1) cycles.
- R2: The divider code m in `rate_cfg_i[10:8]` further divides the prescaler output by m+1 (codes 0..7 give 1..8).
- R3: Only bits 2:0 and 10:8 of `rate_cfg_i` are decoded. Changing bits 7:3 neither restarts the timing nor changes any output.
- R4: `tick_o` is high for exactly one cycle per phase. The first tick comes T cycles after the clock edge that first samples `en_i` high, where T is the phase length from R1.
- R5: `com_idx_o` advances by one on each tick and wraps to 0 after reaching the last active common k = `com_sel_i`. Codes 6 and 7 act as 5.
- R6: `eof_o` pulses for one cycle, together with `tick_o`, exactly when the index wraps to 0.
- R7: While enabled, `com_act_o[i]` is 1 for i ≤ k and 0 for every common above k. While disabled it is all zero.
- R8: The buffer code b in `buf_code_i` sets the drive length in slow periods. Codes 1..7 drive for 2^b slow periods (2^(b+1) cycles). `buf_on_o` rises with each tick and stays high for that length. A tick that arrives while the pulse is still running restarts the pulse.
- R9: Buffer code 8 drives for half a slow period (1 cycle) and code 9 for a full slow period (2 cycles). Code 0 and codes 10..15 never drive.
- R10: A change of either divide code while enabled restarts both counters and the phase index, exactly as a fresh enable does.
- R11: While `en_i` is low, `tick_o`, `eof_o` and `buf_on_o` stay 0 and `com_idx_o` stays 0, whatever the configuration.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock, twice the slow-clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| rate_cfg_i | input | 11 | Frame-rate word: prescaler code [2:0], divider code [10:8] |
| com_sel_i | input | 3 | Index of the last active common |
| buf_code_i | input | 4 | Buffer on-time code |
| tick_o | output | 1 | One-cycle phase tick |
| com_idx_o | output | 3 | Active common-phase index |
| eof_o | output | 1 | End-of-frame strobe |
| buf_on_o | output | 1 | Buffer drive enable |
| com_act_o | output | 6 | Per-common active mask |

## Verification
Directed cases cover the following settings:
- Smallest phase (n=0, m=0), which exposes off-by-one errors in both counters.
- A large prescaler with a small divider, and the reverse, which separates the two stages.
- A single common, the full six commons, and clamped codes 6 and 7.
- Each class of buffer code: half period, full period, a power of two shorter than the phase, one longer than the phase (continuous drive), and the off codes.

Randomized cases mix these fields freely. A mid-run change of the divide codes is checked against a mid-run change of the undecoded bits. This tells a true restart apart from an over-eager compare on the whole word.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned PRE_LSB = 0;
  localparam int unsigned DIV_LSB = 8;
  localparam int unsigned CFG_W   = DIV_LSB + CODE_W;
  localparam int unsigned BUF_W   = 4;

  // Buffer on-time in clk cycles; one slow period = 2**sub_log2 cycles (sub_log2 >= 1)
  function automatic int unsigned buf_cycles(input logic [BUF_W-1:0] code,
                                             input int unsigned sub_log2);
    int unsigned r;
    r = 0;
    if (code >= 4'd1 && code <= 4'd7) r = 32'd1 << (32'(code) + sub_log2);
    else if (code == 4'd8)            r = 32'd1 << (sub_log2 - 1);
    else if (code == 4'd9)            r = 32'd1 << sub_log2;
    return r;
  endfunction
endpackage

// File: rtl/lcdt_divider.sv
module lcdt_divider
  import lcdt_pkg::*;
#(
  parameter int unsigned SUB_LOG2      = 1,
  parameter int unsigned PRE_BASE_LOG2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] presc_code_i,
  input  logic [CODE_W-1:0] div_code_i,
  output logic              step_o
);
  localparam int unsigned SHIFT0 = PRE_BASE_LOG2 + SUB_LOG2;
  localparam int unsigned CNT_W  = SHIFT0 + (1 << CODE_W) - 1;

  logic [CNT_W-1:0]  presc_cnt, presc_last;
  logic [CODE_W-1:0] div_cnt;
  logic              presc_wrap, div_wrap;

  assign presc_last = (CNT_W'(1) << (SHIFT0 + 32'(presc_code_i))) - CNT_W'(1);
  assign presc_wrap = (presc_cnt == presc_last);
  assign div_wrap   = (div_cnt == div_code_i);
  assign step_o     = ~clear_i & presc_wrap & div_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_cnt <= '0;
      div_cnt   <= '0;
    end else if (clear_i) begin
      presc_cnt <= '0;
      div_cnt   <= '0;
    end else if (presc_wrap) begin
      presc_cnt <= '0;
      div_cnt   <= div_wrap ? '0 : div_cnt + 1'b1;
    end else begin
      presc_cnt <= presc_cnt + 1'b1;
    end
  end

  AST_STEP_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (presc_cnt == '0) && (div_cnt == '0)); // R2
  AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (presc_cnt == '0) && !step_o); // R10
endmodule

// File: rtl/lcdt_com_seq.sv
module lcdt_com_seq #(
  parameter int unsigned NUM_COM = 6,
  parameter int unsigned IDX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] com_sel_i,
  output logic [IDX_W-1:0] last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             eof_o
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_COM - 1);

  logic [IDX_W-1:0] idx_q;
  logic             eof_q;

  assign last_o = (com_sel_i > MAX_IDX) ? MAX_IDX : com_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      eof_q <= 1'b0;
    end else if (clear_i) begin
      idx_q <= '0;
      eof_q <= 1'b0;
    end else if (step_i) begin
      // >= also recovers when the common count shrinks mid-frame
      if (idx_q >= last_o) begin
        idx_q <= '0;
        eof_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
        eof_q <= 1'b0;
      end
    end else begin
      eof_q <= 1'b0;
    end
  end

  assign idx_o = idx_q;
  assign eof_o = eof_q;

  AST_EOF_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_q |-> (idx_q == '0)); // R6
  AST_IDX_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> $stable(idx_q)); // R5
endmodule

// File: rtl/lcdt_buf_pulse.sv
module lcdt_buf_pulse
  import lcdt_pkg::*;
#(
  parameter int unsigned SUB_LOG2 = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic [BUF_W-1:0] code_i,
  output logic             on_o
);
  localparam int unsigned LEN_W = (1 << (BUF_W - 1)) + SUB_LOG2;

  logic [LEN_W-1:0] len, cnt_q;
  logic             on_q;

  assign len = LEN_W'(buf_cycles(code_i, SUB_LOG2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else if (clear_i) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && (len != '0)) begin
      on_q  <= 1'b1;
      cnt_q <= len - 1'b1;
    end else if (on_q) begin
      if (cnt_q == '0) on_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign on_o = on_q;

  AST_BUF_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(on_q) |-> $past(start_i)); // R8
  AST_BUF_OFF_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clear_i && (len == '0) && !on_q) |=> !on_q); // R9
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcdt_pkg::*;
#(
  parameter int unsigned SUB_LOG2      = 1,
  parameter int unsigned PRE_BASE_LOG2 = 3,
  parameter int unsigned NUM_COM       = 6,
  parameter int unsigned IDX_W         = $clog2(NUM_COM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [CFG_W-1:0]   rate_cfg_i,
  input  logic [IDX_W-1:0]   com_sel_i,
  input  logic [BUF_W-1:0]   buf_code_i,
  output logic               tick_o,
  output logic [IDX_W-1:0]   com_idx_o,
  output logic               eof_o,
  output logic               buf_on_o,
  output logic [NUM_COM-1:0] com_act_o
);
  logic [CODE_W-1:0]   presc_code, div_code;
  logic [2*CODE_W-1:0] rate_key, rate_key_q;
  logic                en_q, restart, clear, step, tick_q;
  logic [IDX_W-1:0]    last_com;
  logic                unused_cfg;

  assign presc_code = rate_cfg_i[PRE_LSB +: CODE_W];
  assign div_code   = rate_cfg_i[DIV_LSB +: CODE_W];
  assign rate_key   = {div_code, presc_code};
  assign unused_cfg = ^rate_cfg_i[DIV_LSB-1:PRE_LSB+CODE_W];

  // Restart on enable edge or any change of the decoded divide fields
  assign restart = en_i & (~en_q | (rate_key != rate_key_q));
  assign clear   = ~en_i | restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      rate_key_q <= '0;
      tick_q     <= 1'b0;
    end else begin
      en_q       <= en_i;
      rate_key_q <= rate_key;
      tick_q     <= step;
    end
  end

  lcdt_divider #(.SUB_LOG2(SUB_LOG2), .PRE_BASE_LOG2(PRE_BASE_LOG2)) u_div (
    .clk_i, .rst_ni, .clear_i(clear),
    .presc_code_i(presc_code), .div_code_i(div_code), .step_o(step)
  );

  lcdt_com_seq #(.NUM_COM(NUM_COM), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .clear_i(clear), .step_i(step), .com_sel_i,
    .last_o(last_com), .idx_o(com_idx_o), .eof_o
  );

  lcdt_buf_pulse #(.SUB_LOG2(SUB_LOG2)) u_buf (
    .clk_i, .rst_ni, .clear_i(clear), .start_i(step),
    .code_i(buf_code_i), .on_o(buf_on_o)
  );

  for (genvar g = 0; g < NUM_COM; g++) begin : g_act
    assign com_act_o[g] = en_i && (IDX_W'(g) <= last_com);
  end

  assign tick_o = tick_q;

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R4
  AST_EOF_WITH_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> tick_o); // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_o && !eof_o && !buf_on_o && (com_idx_o == '0))); // R11
  AST_ACT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (com_act_o == '0)); // R7
endmodule

// File: tb/lcd_frame_timer_test.sv
module lcd_frame_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [10:0] rate_cfg = '0;
  logic [2:0]  com_sel = '0;
  logic [3:0]  buf_code = '0;
  logic        tick, eof, buf_on;
  logic [2:0]  com_idx;
  logic [5:0]  com_act;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  lcd_frame_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rate_cfg_i(rate_cfg),
    .com_sel_i(com_sel), .buf_code_i(buf_code), .tick_o(tick),
    .com_idx_o(com_idx), .eof_o(eof), .buf_on_o(buf_on), .com_act_o(com_act)
  );

  function automatic int phase_len(int n, int m);
    return (1 << (4 + n)) * (m + 1);
  endfunction

  function automatic int drive_len(int b);
    if (b >= 1 && b <= 7) return 1 << (b + 1);
    if (b == 8) return 1;
    if (b == 9) return 2;
    return 0;
  endfunction

  function automatic int last_com(int k);
    return (k > 5) ? 5 : k;
  endfunction

  task automatic expect_idle(string tag, logic [5:0] act_exp);
    checks++;
    if (tick !== 1'b0 || eof !== 1'b0 || buf_on !== 1'b0 || com_idx !== 3'd0 ||
        com_act !== act_exp) begin
      errors++;
      $display("FAIL %s idle: tick=%b eof=%b buf=%b idx=%0d act=%b expected 0 0 0 0 act=%b",
               tag, tick, eof, buf_on, com_idx, com_act, act_exp);
    end
  endtask

  task automatic run_case(string tag, int n, int m, int k, int b,
                          bit field_restart, bit poke_unused);
    int t, kl, d, ncyc;
    t = phase_len(n, m);
    kl = last_com(k);
    d = drive_len(b);
    ncyc = t * ((kl + 1) * 2 + 1) + 3;
    @(negedge clk);
    if (!field_restart) begin
      en = 1'b0;
      @(negedge clk);
    end
    rate_cfg = '0;
    rate_cfg[2:0] = 3'(n);
    rate_cfg[10:8] = 3'(m);
    com_sel = 3'(k);
    buf_code = 4'(b);
    en = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      int p, ei;
      bit et, ee, eb;
      logic [5:0] ea;
      @(negedge clk);
      p  = c / t;
      et = (c > 0) && (c % t == 0);
      ei = p % (kl + 1);
      ee = et && (ei == 0);
      eb = (p >= 1) && ((c % t) < d);
      ea = 6'((1 << (kl + 1)) - 1);
      checks++;
      if (tick !== et || com_idx !== 3'(ei) || eof !== ee || buf_on !== eb ||
          com_act !== ea) begin
        errors++;
        $display("FAIL %s n=%0d m=%0d k=%0d b=%0d cyc=%0d actual tick=%b idx=%0d eof=%b buf=%b act=%b expected tick=%b idx=%0d eof=%b buf=%b act=%b",
                 tag, n, m, k, b, c, tick, com_idx, eof, buf_on, com_act,
                 et, ei, ee, eb, ea);
      end
      if (poke_unused && c == ncyc / 2) rate_cfg[7:3] = ~rate_cfg[7:3];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // R12: outputs quiet in reset
    rate_cfg = 11'h7ff;
    com_sel = 3'd5;
    buf_code = 4'd9;
    repeat (3) @(negedge clk);
    expect_idle("R12", 6'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: disabled with a busy configuration stays idle
    rate_cfg = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      expect_idle("R11", 6'b0);
    end
    // directed corners
    run_case("R1 R4 R9 half-period", 0, 0, 0, 8, 1'b0, 1'b0);
    run_case("R1 R9 full-period",    1, 0, 2, 9, 1'b0, 1'b0);
    run_case("R2 R5 R6 R8",          0, 3, 5, 1, 1'b0, 1'b0);
    run_case("R2 R9 code-off",       2, 7, 3, 12, 1'b0, 1'b0);
    run_case("R5 R7 clamp R8 long",  0, 1, 7, 7, 1'b0, 1'b0);
    run_case("R1 R8",                3, 1, 1, 3, 1'b0, 1'b0);
    run_case("R9 zero",              0, 2, 4, 0, 1'b0, 1'b0);
    // R3: undecoded bits toggled mid-run do not restart
    run_case("R3",                   1, 2, 2, 2, 1'b0, 1'b1);
    // R10: divide-field change while enabled restarts
    run_case("R10 presc",            0, 2, 2, 2, 1'b1, 1'b0);
    run_case("R10 div",              0, 5, 2, 2, 1'b1, 1'b0);
    // R11 again after running: drop enable mid-frame
    @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      expect_idle("R11 after run", 6'b0);
    end
    // randomized mixes
    for (int r = 0; r < 8; r++) begin
      int n, m, k, b;
      n = int'($urandom_range(1, 0));
      m = int'($urandom_range(7, 0));
      k = int'($urandom_range(7, 0));
      b = int'($urandom_range(15, 0));
      run_case("R1 R2 R5 R6 R7 R8 R9 random", n, m, k, b, 1'b0, 1'b0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule